// File: doc/BRIEF.md
# Legacy System Control Port Decoder

This block is a byte-wide register file mapped into a small window of host I/O space. A host issues single-cycle writes (address, write strobe, data) and combinational reads (address, read strobe). The block keeps a handful of system control bytes and turns selected bits of them into level outputs for the rest of the chip. These outputs are an alternate A20 gate, a serial port enable, a parallel port enable, and the I/O base chosen for that parallel port. One variant also produces a single-cycle CPU reset request.

A static configuration input chooses between two flavours of the port set. In the plain flavour (`variant_sel` = 0), bit 0 of the fast-control byte at 0x92 is an ordinary storage bit, and reads of 0x102 show bit 3 forced high. In the reset-capable flavour (`variant_sel` = 1), writing bit 0 of 0x92 as 1 raises a one-cycle reset request and the bit is not retained, and reads of 0x105 show bit 7 forced high. The serial and parallel controllers, the real A20 gate and the reset sequencer sit outside this block.

Top module: `sysctl_port_decoder`

## Requirements
- R1: After reset, the parallel port is enabled with base 0x3BC, the serial enable, the A20 output and the reset request are low, and every stored byte (0x92, 0x94, 0x102, 0x103, 0x104, 0x105, 0x190) is 0x00.
- R2: A write to 0x92 stores the byte, and from the next cycle `a20_alt_en` equals bit 1 of the written value.
- R3: With `variant_sel` = 1, a write to 0x92 with bit 0 set drives `cpu_reset_req` high for exactly the one cycle after the write, and bit 0 reads back as 0. With `variant_sel` = 0 no request is issued and bit 0 is kept as written.
- R4: A write to 0x102 sets `serial_en` to bit 2 of the written value from the next cycle.
- R5: A write to 0x102 always drops the parallel enable first. If bit 4 is 1 and bits 6:5 are 0, 1 or 2, the port is enabled with base 0x3BC, 0x378 or 0x278. If bit 4 is 0 or bits 6:5 are 3, the port stays disabled and `lpt_base` keeps its previous value.
- R6: A read of 0x91 returns 0x00. A read of any address not listed in R1 or here returns 0xFF. While `bus_rd` is low, `bus_rdata` is 0x00.
- R7: With `variant_sel` = 0, reads of 0x102 return the stored byte with bit 3 forced to 1. With `variant_sel` = 1, reads of 0x105 return the stored byte with bit 7 forced to 1. In each flavour the other port reads back unmodified.
- R8: 0x94, 0x103, 0x104, 0x190 and 0x105 read back the last byte written, and 0x102 does too apart from the R7 bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_sel | input | 1 | 0: plain flavour, 1: reset-capable flavour |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| a20_alt_en | output | 1 | Alternate A20 gate enable |
| cpu_reset_req | output | 1 | One-cycle CPU reset request |
| serial_en | output | 1 | First serial port enable |
| lpt_en | output | 1 | Parallel port enable |
| lpt_base | output | 16 | Parallel port I/O base |

## Verification
The bench builds the block with the default 16-bit address width. That width lets it probe decode aliasing: addresses such as 0x192, 0x202 or 0x1102 differ from a mapped port only in upper bits and must still read 0xFF. It runs both flavours, switching `variant_sel` only under reset. This brings the reset pulse, the retained-versus-cleared bit 0 and the two forced readback bits within reach against the same reference model. It steps the parallel select through all four codes to cover the held base on code 3.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W   = 8;
    localparam int BASE_W   = 16;
    localparam int NUM_PORT = 8;

    // Index of each decoded port inside the hit vector
    localparam int P_ZERO  = 0;
    localparam int P_FAST  = 1;
    localparam int P_GP94  = 2;
    localparam int P_PERIF = 3;
    localparam int P_GP103 = 4;
    localparam int P_GP104 = 5;
    localparam int P_GP105 = 6;
    localparam int P_GP190 = 7;

    localparam logic [15:0] PORT_ADDR [NUM_PORT] = '{
        16'h0091, 16'h0092, 16'h0094, 16'h0102,
        16'h0103, 16'h0104, 16'h0105, 16'h0190
    };

    // Bit positions inside the peripheral control byte
    localparam int PB_SERIAL = 2;
    localparam int PB_LPT_ON = 4;
    localparam int PB_SEL_LO = 5;

    typedef enum logic [1:0] {
        LPT_SEL_MONO = 2'd0,
        LPT_SEL_PRI  = 2'd1,
        LPT_SEL_SEC  = 2'd2,
        LPT_SEL_HOLD = 2'd3
    } lpt_sel_e;

    localparam logic [BASE_W-1:0] LPT_BASE_MONO = 16'h03BC;
    localparam logic [BASE_W-1:0] LPT_BASE_PRI  = 16'h0378;
    localparam logic [BASE_W-1:0] LPT_BASE_SEC  = 16'h0278;

    typedef struct packed {
        logic [DATA_W-1:0] fast_ctl;
        logic [DATA_W-1:0] gp94;
        logic [DATA_W-1:0] perif_ctl;
        logic [DATA_W-1:0] gp103;
        logic [DATA_W-1:0] gp104;
        logic [DATA_W-1:0] gp105;
        logic [DATA_W-1:0] gp190;
        logic              lpt_on;
        logic [BASE_W-1:0] lpt_base;
        logic              rst_pulse;
    } sysctl_state_t;

    localparam sysctl_state_t STATE_RESET = '{
        fast_ctl:  '0,
        gp94:      '0,
        perif_ctl: '0,
        gp103:     '0,
        gp104:     '0,
        gp105:     '0,
        gp190:     '0,
        lpt_on:    1'b1,
        lpt_base:  LPT_BASE_MONO,
        rst_pulse: 1'b0
    };

endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_PORT-1:0] hit
);

    genvar g;
    generate
        for (g = 0; g < NUM_PORT; g++) begin : g_cmp
            assign hit[g] = (addr == ADDR_W'(PORT_ADDR[g]));
        end
    endgenerate

endmodule

// File: rtl/sysctl_lpt_ctrl.sv
module sysctl_lpt_ctrl
    import sysctl_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  logic [BASE_W-1:0] cur_base,
    output logic              nxt_on,
    output logic [BASE_W-1:0] nxt_base
);

    lpt_sel_e sel;

    always_comb begin
        sel      = lpt_sel_e'(wdata[PB_SEL_LO +: 2]);
        // Every write drops the port; it comes back only on a valid select
        nxt_on   = 1'b0;
        nxt_base = cur_base;
        if (wdata[PB_LPT_ON]) begin
            case (sel)
                LPT_SEL_MONO: begin nxt_on = 1'b1; nxt_base = LPT_BASE_MONO; end
                LPT_SEL_PRI:  begin nxt_on = 1'b1; nxt_base = LPT_BASE_PRI;  end
                LPT_SEL_SEC:  begin nxt_on = 1'b1; nxt_base = LPT_BASE_SEC;  end
                default:      begin nxt_on = 1'b0; nxt_base = cur_base;      end
            endcase
        end
    end

endmodule

// File: rtl/sysctl_readback.sv
module sysctl_readback
    import sysctl_pkg::*;
(
    input  logic                rd,
    input  logic                variant,
    input  logic [NUM_PORT-1:0] hit,
    input  sysctl_state_t       st,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] perif_view;
    logic [DATA_W-1:0] gp105_view;

    always_comb begin
        perif_view = st.perif_ctl | (variant ? 8'h00 : 8'h08);
        gp105_view = st.gp105     | (variant ? 8'h80 : 8'h00);
        rdata = 8'hFF;
        if (!rd) begin
            rdata = 8'h00;
        end else begin
            unique case (1'b1)
                hit[P_ZERO]:  rdata = 8'h00;
                hit[P_FAST]:  rdata = st.fast_ctl;
                hit[P_GP94]:  rdata = st.gp94;
                hit[P_PERIF]: rdata = perif_view;
                hit[P_GP103]: rdata = st.gp103;
                hit[P_GP104]: rdata = st.gp104;
                hit[P_GP105]: rdata = gp105_view;
                hit[P_GP190]: rdata = st.gp190;
                default:      rdata = 8'hFF;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_port_decoder.sv
module sysctl_port_decoder
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              variant_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              a20_alt_en,
    output logic              cpu_reset_req,
    output logic              serial_en,
    output logic              lpt_en,
    output logic [15:0]       lpt_base
);

    sysctl_state_t       st_d, st_q;
    logic [NUM_PORT-1:0] hit;
    logic                lpt_on_n;
    logic [BASE_W-1:0]   lpt_base_n;

    sysctl_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    sysctl_lpt_ctrl u_lpt (
        .wdata    (bus_wdata),
        .cur_base (st_q.lpt_base),
        .nxt_on   (lpt_on_n),
        .nxt_base (lpt_base_n)
    );

    sysctl_readback u_rb (
        .rd      (bus_rd),
        .variant (variant_sel),
        .hit     (hit),
        .st      (st_q),
        .rdata   (bus_rdata)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;
        if (bus_wr) begin
            if (hit[P_FAST]) begin
                st_d.fast_ctl  = variant_sel ? {bus_wdata[7:1], 1'b0} : bus_wdata;
                st_d.rst_pulse = variant_sel & bus_wdata[0];
            end
            if (hit[P_GP94])  st_d.gp94  = bus_wdata;
            if (hit[P_PERIF]) begin
                st_d.perif_ctl = bus_wdata;
                st_d.lpt_on    = lpt_on_n;
                st_d.lpt_base  = lpt_base_n;
            end
            if (hit[P_GP103]) st_d.gp103 = bus_wdata;
            if (hit[P_GP104]) st_d.gp104 = bus_wdata;
            if (hit[P_GP105]) st_d.gp105 = bus_wdata;
            if (hit[P_GP190]) st_d.gp190 = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= STATE_RESET;
        else        st_q <= st_d;
    end

    assign a20_alt_en    = st_q.fast_ctl[1];
    assign cpu_reset_req = st_q.rst_pulse;
    assign serial_en     = st_q.perif_ctl[PB_SERIAL];
    assign lpt_en        = st_q.lpt_on;
    assign lpt_base      = st_q.lpt_base;

endmodule

// File: rtl/sysctl_port_checker.sv
module sysctl_port_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              variant_sel,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              a20_alt_en,
    input logic              cpu_reset_req,
    input logic              serial_en,
    input logic              lpt_en,
    input logic [15:0]       lpt_base
);

    logic wr_fast, wr_perif, mapped;
    assign wr_fast  = bus_wr && (bus_addr == ADDR_W'(16'h0092));
    assign wr_perif = bus_wr && (bus_addr == ADDR_W'(16'h0102));
    assign mapped   = (bus_addr == ADDR_W'(16'h0091)) || (bus_addr == ADDR_W'(16'h0092)) ||
                      (bus_addr == ADDR_W'(16'h0094)) || (bus_addr == ADDR_W'(16'h0102)) ||
                      (bus_addr == ADDR_W'(16'h0103)) || (bus_addr == ADDR_W'(16'h0104)) ||
                      (bus_addr == ADDR_W'(16'h0105)) || (bus_addr == ADDR_W'(16'h0190));

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_req |=> !cpu_reset_req); // R3
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_req |-> $past(variant_sel && wr_fast && bus_wdata[0])); // R3
    AST_A20_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fast |=> (a20_alt_en == $past(bus_wdata[1]))); // R2
    AST_SERIAL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_perif |=> (serial_en == $past(bus_wdata[2]))); // R4
    AST_LPT_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_perif && (!bus_wdata[4] || bus_wdata[6:5] == 2'd3)) |=> (!lpt_en && $stable(lpt_base))); // R5
    AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |-> (bus_rdata == 8'hFF)); // R6
    AST_ZERO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(16'h0091)) |-> (bus_rdata == 8'h00)); // R6

endmodule

bind sysctl_port_decoder sysctl_port_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sysctl_port_decoder.sv
`timescale 1ns/1ps
module sim_sysctl_port_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant_sel = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        a20_alt_en, cpu_reset_req, serial_en, lpt_en;
    logic [15:0] lpt_base;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    logic [7:0]  m92, m94, m102, m103, m104, m105, m190;
    logic        m_lpt_on, m_pulse;
    logic [15:0] m_base;

    always #2.5 clk = ~clk;

    sysctl_port_decoder #(.ADDR_W(16)) u0 (
        .clk, .rst_n, .variant_sel, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
        .bus_rdata, .a20_alt_en, .cpu_reset_req, .serial_en, .lpt_en, .lpt_base
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [15:0] a);
        if (!bus_rd) return 8'h00;
        case (a)
            16'h0091: return 8'h00;
            16'h0092: return m92;
            16'h0094: return m94;
            16'h0102: return m102 | (variant_sel ? 8'h00 : 8'h08);
            16'h0103: return m103;
            16'h0104: return m104;
            16'h0105: return m105 | (variant_sel ? 8'h80 : 8'h00);
            16'h0190: return m190;
            default:  return 8'hFF;
        endcase
    endfunction

    task automatic compare_all();
        chk("R2 a20", {15'd0, a20_alt_en}, {15'd0, m92[1]});
        chk("R3 reset_req", {15'd0, cpu_reset_req}, {15'd0, m_pulse});
        chk("R4 serial", {15'd0, serial_en}, {15'd0, m102[2]});
        chk("R5 lpt_en", {15'd0, lpt_en}, {15'd0, m_lpt_on});
        chk("R5 lpt_base", lpt_base, m_base);
        chk("R8 rdata", {8'd0, bus_rdata}, {8'd0, model_read(bus_addr)});
    endtask

    task automatic model_reset();
        m92 = 0; m94 = 0; m102 = 0; m103 = 0; m104 = 0; m105 = 0; m190 = 0;
        m_lpt_on = 1'b1; m_base = 16'h03BC; m_pulse = 1'b0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        case (a)
            16'h0092: begin
                m92 = variant_sel ? (d & 8'hFE) : d;
                m_pulse = variant_sel & d[0];
            end
            16'h0094: m94 = d;
            16'h0102: begin
                m102 = d;
                m_lpt_on = 1'b0;
                if (d[4]) begin
                    if (d[6:5] == 2'd0) begin m_lpt_on = 1'b1; m_base = 16'h03BC; end
                    if (d[6:5] == 2'd1) begin m_lpt_on = 1'b1; m_base = 16'h0378; end
                    if (d[6:5] == 2'd2) begin m_lpt_on = 1'b1; m_base = 16'h0278; end
                end
            end
            16'h0103: m103 = d;
            16'h0104: m104 = d;
            16'h0105: m105 = d;
            16'h0190: m190 = d;
            default: ;
        endcase
    endtask

    task automatic step_idle();
        @(negedge clk);
        compare_all();
        m_pulse = 1'b0;
        bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        compare_all();
        m_pulse = 1'b0;
        bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
        model_write(a, d);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        compare_all();
        m_pulse = 1'b0;
        bus_wr = 0; bus_rd = 1; bus_addr = a; bus_wdata = '0;
        #1;
        chk(tag, {8'd0, bus_rdata}, {8'd0, exp});
    endtask

    task automatic do_reset(input logic v);
        @(negedge clk);
        rst_n = 0; variant_sel = v;
        bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
        chk("R1 lpt_en", {15'd0, lpt_en}, 16'd1);
        chk("R1 lpt_base", lpt_base, 16'h03BC);
        chk("R1 serial", {15'd0, serial_en}, 16'd0);
        chk("R1 a20", {15'd0, a20_alt_en}, 16'd0);
        chk("R1 reset_req", {15'd0, cpu_reset_req}, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // ---------- plain flavour ----------
        do_reset(1'b0);
        do_read(16'h0092, 8'h00, "R1 fast_ctl");
        do_read(16'h0190, 8'h00, "R1 gp190");
        do_read(16'h0102, 8'h08, "R7 forced bit3");
        do_read(16'h0105, 8'h00, "R7 no force 105");
        do_read(16'h0091, 8'h00, "R6 zero port");
        do_read(16'h0200, 8'hFF, "R6 unmapped");
        do_read(16'h0192, 8'hFF, "R6 alias 192");
        do_read(16'h1102, 8'hFF, "R6 alias 1102");
        do_write(16'h0092, 8'h03);
        step_idle();
        chk("R2 a20 set", {15'd0, a20_alt_en}, 16'd1);
        chk("R3 no pulse plain", {15'd0, cpu_reset_req}, 16'd0);
        do_read(16'h0092, 8'h03, "R3 bit0 kept");
        do_write(16'h0102, 8'h14);
        step_idle();
        chk("R5 sel0", lpt_base, 16'h03BC);
        chk("R4 serial on", {15'd0, serial_en}, 16'd1);
        do_write(16'h0102, 8'h34);
        step_idle();
        chk("R5 sel1", lpt_base, 16'h0378);
        do_write(16'h0102, 8'h50);
        step_idle();
        chk("R5 sel2", lpt_base, 16'h0278);
        chk("R4 serial off", {15'd0, serial_en}, 16'd0);
        do_write(16'h0102, 8'h70);
        step_idle();
        chk("R5 sel3 off", {15'd0, lpt_en}, 16'd0);
        chk("R5 sel3 base held", lpt_base, 16'h0278);
        do_write(16'h0102, 8'h34);
        do_write(16'h0102, 8'h24);
        step_idle();
        chk("R5 bit4 clear off", {15'd0, lpt_en}, 16'd0);
        chk("R5 bit4 clear base", lpt_base, 16'h0378);
        do_read(16'h0102, 8'h2C, "R7 forced over stored");
        do_write(16'h0094, 8'hA5);
        do_write(16'h0103, 8'h5A);
        do_write(16'h0104, 8'hC3);
        do_write(16'h0105, 8'h81);
        do_write(16'h0190, 8'h7E);
        do_read(16'h0094, 8'hA5, "R8 gp94");
        do_read(16'h0103, 8'h5A, "R8 gp103");
        do_read(16'h0104, 8'hC3, "R8 gp104");
        do_read(16'h0105, 8'h81, "R8 gp105");
        do_read(16'h0190, 8'h7E, "R8 gp190");
        do_write(16'h0300, 8'h00);
        do_read(16'h0094, 8'hA5, "R6 unmapped write ignored");
        for (int i = 0; i < 256; i += 37) begin
            do_write(16'h0092, 8'(i));
            do_read(16'h0092, 8'(i), "R2 sweep");
        end
        step_idle();

        // ---------- reset-capable flavour ----------
        do_reset(1'b1);
        do_read(16'h0102, 8'h00, "R7 no force 102");
        do_read(16'h0105, 8'h80, "R7 forced bit7");
        do_write(16'h0092, 8'h01);
        step_idle();
        chk("R3 pulse high", {15'd0, cpu_reset_req}, 16'd1);
        step_idle();
        chk("R3 pulse low", {15'd0, cpu_reset_req}, 16'd0);
        do_read(16'h0092, 8'h00, "R3 bit0 cleared");
        do_write(16'h0092, 8'h03);
        do_write(16'h0092, 8'h02);
        step_idle();
        chk("R3 no pulse bit0 clear", {15'd0, cpu_reset_req}, 16'd0);
        chk("R2 a20 kept", {15'd0, a20_alt_en}, 16'd1);
        do_write(16'h0105, 8'h12);
        do_read(16'h0105, 8'h92, "R7 forced over stored 105");
        do_write(16'h0102, 8'h54);
        step_idle();
        chk("R5 sel2 v1", lpt_base, 16'h0278);
        do_read(16'h0102, 8'h54, "R8 perif plain v1");
        step_idle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule